// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave model of a 4096 x 8 byte-addressable EEPROM on a two-wire serial bus. It takes clock and data lines that are already synchronised to the system clock. It pulls the data line low through an open-drain output enable. It detects START and STOP events and compares the incoming control byte with a fixed device code and three strap inputs. It then loads a two-byte word address and serves byte writes, page writes of up to 32 bytes, current-address reads, random reads and sequential reads.

Written bytes first collect in a 32-entry page latch. They reach the array only when a STOP ends the write. A self-timed write cycle then runs for a parameterised number of system clocks. During that cycle the slave answers nothing, so a master can poll it for completion. A write-protect input is sampled at the STOP. When it is high, the transfer is acknowledged as normal but the data is thrown away.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, and whenever no transfer is addressed to it, the slave leaves the data line released (sda_oe = 0). It changes sda_oe only while the clock line is low. A START is the data line falling while the clock line is high, and a STOP is the data line rising while the clock line is high.
- R2: The first byte after a START is acknowledged only if its upper four bits are 1010 and bits 3..1 equal cs_strap; bit 0 selects read (1) or write (0). When there is no match, the slave stays silent until the next START or STOP.
- R3: A write control byte is followed by two address bytes, high byte first. Only the low four bits of the high byte are used, which gives a 12-bit address.
- R4: Each data byte of a write advances only the low five address bits. Past offset 31 the write wraps to offset 0 of the same 32-byte page.
- R5: If more than 32 data bytes are sent, the last byte sent to each offset is the one kept. Page offsets that received no byte keep their previous array contents.
- R6: The array update and a busy period of WRITE_CYCLES clocks (at least 32) begin at the STOP that ends a write with at least one full data byte. During the busy period the slave acknowledges no byte, including its own control byte.
- R7: write-protect is sampled at the STOP. If it is high, every byte was acknowledged, the array is unchanged, and the slave accepts a new command at once with no busy period.
- R8: A read returns the byte at the address pointer, and the pointer then steps by one. It rolls over from 0xFFF to 0x000. The master acknowledges a byte to get the next one and sends a NACK to end the read.
- R9: A current-address read returns the byte that follows the last one accessed. After a write the pointer rests at the address after the last byte written, wrapping within the page.
- R10: A repeated START after the two address bytes ends the write phase but keeps the loaded pointer, so a read control byte that follows reads from that address.
- R11: A START that comes before a write's closing STOP discards every data byte latched so far. It does not begin a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, already synchronised |
| sda_i | input | 1 | Bus data line as observed (wired-AND), already synchronised |
| sda_oe | output | 1 | Registered open-drain enable; 1 pulls the data line low |
| wp_i | input | 1 | Write-protect level, sampled at STOP |
| cs_strap | input | 3 | Chip-select straps compared with control byte bits 3..1 |

## Verification
The assertions assume a master that obeys the bus: its data line changes only while the clock is low, except for START and STOP. They also assume each clock phase lasts several system clocks, so a registered change of sda_oe always falls inside the low phase. They further assume the master never issues START or STOP while the slave is pulling the line low. The bench master meets these assumptions by construction. It moves data a quarter bit period after each falling clock edge, holds every phase for three system clocks, and only issues START or STOP after an acknowledge slot or a NACKed byte, when the slave has released the line.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } slv_state_e;

  typedef enum logic [1:0] {
    K_CTRL,
    K_AHI,
    K_ALO,
    K_DATA
  } rx_kind_e;
endpackage

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
endmodule

// File: rtl/page_latch.sv
module page_latch #(
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              clr,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  localparam int ENTRIES = 1 << PAGE_W;

  logic [7:0]         buf_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) buf_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  assign rd_data   = buf_q[rd_idx];
  assign rd_valid  = vld_q[rd_idx];
  assign any_valid = |vld_q;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       wp_i,
  input  logic [2:0] cs_strap
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BUSY_CYC   = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;
  localparam int CW         = $clog2(BUSY_CYC + 1);
  localparam int HI_W       = ADDR_W - 8;
  localparam int BASE_W     = ADDR_W - PAGE_W;

  logic start_ev, stop_ev, scl_rise, scl_fall;

  bus_cond_detect u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start_ev), .stop_o(stop_ev), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  slv_state_e         state;
  rx_kind_e           kind;
  logic               rw_q;
  logic [3:0]         cnt;
  logic [7:0]         rx_sh;
  logic [7:0]         tx_sh;
  logic               m_ack;
  logic [HI_W-1:0]    addr_hi;
  logic [ADDR_W-1:0]  ptr;
  logic               oe_q;

  logic               wr_busy;
  logic [CW-1:0]      bcnt;
  logic [BASE_W-1:0]  page_base;

  logic [7:0]         arr_rdata;
  logic [7:0]         lat_rdata;
  logic               lat_rvalid, lat_any;
  logic               lat_we, lat_clr;
  logic [PAGE_W-1:0]  commit_idx;
  logic               commit_go, commit_done, arr_we;
  logic               byte_done, ctrl_match;

  assign byte_done   = (state == ST_RX) && scl_fall && (cnt == 4'd8);
  assign ctrl_match  = (rx_sh[7:4] == DEV_CODE) && (rx_sh[3:1] == cs_strap) && !wr_busy;
  assign lat_we      = byte_done && (kind == K_DATA);
  assign commit_go   = stop_ev && !wr_busy && (kind == K_DATA) && lat_any && !wp_i;
  assign commit_done = wr_busy && (bcnt == CW'(BUSY_CYC - 1));
  assign lat_clr     = (!wr_busy && (start_ev || stop_ev) && !commit_go) || commit_done;
  assign commit_idx  = bcnt[PAGE_W-1:0];
  assign arr_we      = wr_busy && (bcnt < CW'(PAGE_BYTES)) && lat_rvalid;

  page_latch #(.PAGE_W(PAGE_W)) u_latch (
    .clk(clk), .rst(rst),
    .wr_en(lat_we), .wr_idx(ptr[PAGE_W-1:0]), .wr_data(rx_sh),
    .clr(lat_clr), .rd_idx(commit_idx),
    .rd_data(lat_rdata), .rd_valid(lat_rvalid), .any_valid(lat_any)
  );

  eeprom_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(arr_we),
    .waddr({page_base, commit_idx}), .wdata(lat_rdata),
    .raddr(ptr), .rdata(arr_rdata)
  );

  // self-timed write cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_busy   <= 1'b0;
      bcnt      <= '0;
      page_base <= '0;
    end else if (commit_go) begin
      wr_busy   <= 1'b1;
      bcnt      <= '0;
      page_base <= ptr[ADDR_W-1:PAGE_W];
    end else if (wr_busy) begin
      bcnt <= bcnt + 1'b1;
      if (commit_done) wr_busy <= 1'b0;
    end
  end

  // bus protocol engine
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      kind    <= K_CTRL;
      rw_q    <= 1'b0;
      cnt     <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      m_ack   <= 1'b0;
      addr_hi <= '0;
      ptr     <= '0;
      oe_q    <= 1'b0;
    end else if (start_ev) begin
      state <= ST_RX;
      kind  <= K_CTRL;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE;
      kind  <= K_CTRL;
      oe_q  <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            rx_sh <= {rx_sh[6:0], sda_i};
            cnt   <= cnt + 1'b1;
          end else if (byte_done) begin
            cnt <= '0;
            case (kind)
              K_CTRL: begin
                if (ctrl_match) begin
                  oe_q  <= 1'b1;
                  state <= ST_ACK;
                  rw_q  <= rx_sh[0];
                  kind  <= rx_sh[0] ? K_CTRL : K_AHI;
                end else begin
                  state <= ST_IGNORE;
                end
              end
              K_AHI: begin
                addr_hi <= rx_sh[HI_W-1:0];
                kind    <= K_ALO;
                oe_q    <= 1'b1;
                state   <= ST_ACK;
              end
              K_ALO: begin
                ptr   <= {addr_hi, rx_sh};
                kind  <= K_DATA;
                oe_q  <= 1'b1;
                state <= ST_ACK;
              end
              default: begin
                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                oe_q  <= 1'b1;
                state <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              tx_sh <= arr_rdata;
              ptr   <= ptr + 1'b1;
              cnt   <= '0;
              oe_q  <= ~arr_rdata[7];
              state <= ST_TX;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              oe_q  <= 1'b0;
              state <= ST_RACK;
            end else begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              oe_q  <= ~tx_sh[6];
              cnt   <= cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_i;
          end else if (scl_fall) begin
            if (m_ack) begin
              tx_sh <= arr_rdata;
              ptr   <= ptr + 1'b1;
              cnt   <= '0;
              oe_q  <= ~arr_rdata[7];
              state <= ST_TX;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/eeprom_slave_checker.sv
module eeprom_slave_checker #(
  parameter int BUSY_CYC = 64
) (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_oe,
  input logic wp_i,
  input logic busy
);
  int bcnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) bcnt <= 0;
    else bcnt <= bcnt + 1;
  end

  // R1: line released after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) rst |=> !sda_oe);

  // R1: output enable moves only in the clock-low phase
  a_r1_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  // R6: no acknowledge or data while the write cycle runs
  a_r6_silent_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);

  // R6: write cycle length bounded by the parameter
  a_r6_busy_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt < BUSY_CYC));

  // R7: a write cycle never starts with write-protect high at the STOP
  a_r7_wp_blocks_cycle: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(wp_i));
endmodule

bind serial_eeprom_slave eeprom_slave_checker #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .wp_i(wp_i), .busy(wr_busy)
);

// File: tb/tb_serial_eeprom_slave.sv
module tb_serial_eeprom_slave;
  localparam int WCYC = 300;
  localparam int Q    = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       wp = 1'b0;
  logic [2:0] cs = 3'b101;
  logic       sda_oe;
  logic       sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  serial_eeprom_slave #(.ADDR_W(12), .PAGE_W(5), .WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wp_i(wp), .cs_strap(cs)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit may_drive = 1'b0;

  logic [7:0] mem_m [0:4095];
  int         mptr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1: every clock, the slave may pull the line only in a slot the model grants
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (sda_oe && !may_drive) begin
        fails++;
        $display("FAIL R1 bus ownership actual=%0h expected=%0h", 1, 0);
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) begin
        sda_m = b[0]; wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        scl_m = 1'b0; may_drive = 1'b1; wq(Q);
      end else begin
        send_bit(b[i]);
      end
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    acked = ~sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
    may_drive = 1'b0;
  endtask

  task automatic rx_byte(input bit give_ack, output logic [7:0] b);
    may_drive = 1'b1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_line; wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    may_drive = 1'b0;
    sda_m = ~give_ack; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; may_drive = give_ack; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic poll(output bit acked);
    bus_start;
    tx_byte({4'hA, cs, 1'b0}, acked);
    bus_stop;
  endtask

  task automatic wait_ready(input string req);
    bit a = 1'b0;
    int n = 0;
    while (!a && n < 40) begin
      poll(a);
      n++;
    end
    chk(a, req, n, 1);
  endtask

  task automatic do_write(input int addr, input int n, input int seed,
                          input bit wp_body, input bit wp_stop, input string req);
    logic [7:0]  pb [32];
    bit          pv [32];
    logic [11:0] ad;
    logic [7:0]  d;
    int          idx;
    bit          a;
    bit          all_a;
    ad = addr[11:0];
    for (int i = 0; i < 32; i++) pv[i] = 1'b0;
    wp = wp_body;
    all_a = 1'b1;
    bus_start;
    tx_byte({4'hA, cs, 1'b0}, a); all_a &= a;
    tx_byte({4'h9, ad[11:8]}, a); all_a &= a;
    tx_byte(ad[7:0], a); all_a &= a;
    idx = int'(ad[4:0]);
    for (int k = 0; k < n; k++) begin
      d = 8'((seed + k * 29) & 255);
      tx_byte(d, a); all_a &= a;
      pb[idx] = d; pv[idx] = 1'b1;
      idx = (idx + 1) % 32;
    end
    wp = wp_stop; wq(1);
    bus_stop;
    wp = 1'b0;
    chk(all_a, req, all_a, 1);
    if (!wp_stop)
      for (int i = 0; i < 32; i++)
        if (pv[i]) mem_m[{ad[11:5], 5'(i)}] = pb[i];
    mptr = int'({ad[11:5], 5'(idx)});
  endtask

  task automatic do_read(input bit random, input int addr, input int n, input string req);
    logic [11:0] ad;
    logic [7:0]  b;
    bit          a;
    ad = addr[11:0];
    if (random) begin
      bus_start;
      tx_byte({4'hA, cs, 1'b0}, a);
      tx_byte({4'h0, ad[11:8]}, a);
      tx_byte(ad[7:0], a);
      chk(a, req, a, 1);
      mptr = addr;
    end
    bus_start;
    tx_byte({4'hA, cs, 1'b1}, a);
    chk(a, req, a, 1);
    for (int k = 0; k < n; k++) begin
      rx_byte(k < n - 1, b);
      chk(b === mem_m[mptr], req, b, mem_m[mptr]);
      mptr = (mptr + 1) % 4096;
    end
    bus_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    for (int i = 0; i < 4096; i++) mem_m[i] = 8'h00;
    wq(5);
    rst = 1'b0;
    wq(2);
    chk(sda_oe == 1'b0, "R1 reset state", sda_oe, 0);

    // R2: wrong chip select, then a further byte: both unanswered
    bus_start;
    tx_byte({4'hA, cs ^ 3'b001, 1'b0}, a);
    chk(!a, "R2 cs mismatch", a, 0);
    tx_byte(8'h00, a);
    chk(!a, "R2 silent until START", a, 0);
    bus_stop;
    // R2: wrong device code
    bus_start;
    tx_byte({4'hB, cs, 1'b0}, a);
    chk(!a, "R2 code mismatch", a, 0);
    bus_stop;

    // page of known contents, then a byte write with junk in the high nibble (R3)
    do_write(12'h120, 8, 8'h10, 1'b0, 1'b0, "R4 page write acks");
    wait_ready("R6 ready after page write");
    do_write(12'h123, 1, 8'h3C, 1'b0, 1'b0, "R3 byte write acks");
    poll(a);
    chk(!a, "R6 busy after STOP", a, 0);
    wait_ready("R6 ready after busy");

    // R10 random read, R9 current read
    do_read(1'b1, 12'h123, 1, "R10 random read");
    do_read(1'b0, 0, 1, "R9 current address read");

    // R9: pointer after a write
    do_write(12'h125, 1, 8'h77, 1'b0, 1'b0, "R9 write acks");
    wait_ready("R6 ready");
    do_read(1'b0, 0, 1, "R9 pointer after write");

    // R4 wrap inside page, R5 untouched offsets preserved
    do_write(12'h040, 32, 8'h01, 1'b0, 1'b0, "R4 fill page");
    wait_ready("R6 ready");
    do_write(12'h05C, 6, 8'hC3, 1'b0, 1'b0, "R4 wrap write");
    wait_ready("R6 ready");
    do_read(1'b1, 12'h040, 32, "R4 R5 page contents after wrap");

    // R5: overrun keeps the last 32 bytes
    do_write(12'h0A0, 35, 8'h55, 1'b0, 1'b0, "R5 overrun acks");
    wait_ready("R6 ready");
    do_read(1'b1, 12'h0A0, 32, "R5 overrun contents");

    // R7: protected write acked, discarded, no busy
    do_write(12'h123, 1, 8'h99, 1'b1, 1'b1, "R7 protected acks");
    poll(a);
    chk(a, "R7 no busy when protected", a, 1);
    do_read(1'b1, 12'h123, 1, "R7 array unchanged");
    // R7: level taken at STOP only
    do_write(12'h130, 1, 8'h6E, 1'b1, 1'b0, "R7 wp low at STOP acks");
    wait_ready("R7 write done when low at STOP");
    do_read(1'b1, 12'h130, 1, "R7 committed");

    // R8 rollover
    do_write(12'hFFF, 1, 8'hE1, 1'b0, 1'b0, "R8 top byte");
    wait_ready("R6 ready");
    do_write(12'h000, 2, 8'h2B, 1'b0, 1'b0, "R8 bottom bytes");
    wait_ready("R6 ready");
    do_read(1'b1, 12'hFFF, 2, "R8 rollover read");
    do_read(1'b0, 0, 1, "R8 pointer after NACK");

    // R11: START during a write discards latched data
    do_write(12'h200, 1, 8'h11, 1'b0, 1'b0, "R11 setup");
    wait_ready("R6 ready");
    bus_start;
    tx_byte({4'hA, cs, 1'b0}, a);
    tx_byte(8'h02, a);
    tx_byte(8'h00, a);
    tx_byte(8'hEE, a);
    chk(a, "R11 data acked", a, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start;
    tx_byte({4'hA, cs, 1'b0}, a);
    chk(a, "R11 no write cycle after abort", a, 1);
    bus_stop;
    do_read(1'b1, 12'h200, 1, "R11 array unchanged");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule